// File: doc/BRIEF.md
# Byte-Indexed Vector Table Lookup

This block assembles a 64-bit word one byte lane at a time. Each of the eight lanes takes an unsigned 8-bit index from the index operand and uses it to select one byte from a table. The table is a run of one to four consecutive 64-bit registers held in a local register file. When a lane's index falls outside the table, that lane passes the matching byte of a default operand through unchanged.

The local register file has 32 entries of 64 bits and one synchronous write port, so software or a sequencer can load the table before issuing lookups. A lookup is issued by pulsing the start strobe together with a descriptor, the index word and the default word. The descriptor carries the table length code and the first register of the table. The assembled result appears one cycle later with a single-cycle done pulse. A new lookup may be issued on every cycle.

Top module: `byte_tbl_lookup`

## Requirements
- R1: The descriptor holds the length code in bits [1:0] and the base register number in bits [6:2]. A length code L selects a table of L+1 registers, which is (L+1)*8 bytes.
- R2: Result bits [8k+7:8k] depend only on bits [8k+7:8k] of the index word and of the default word, for k = 0..7.
- R3: For an in-range index i, the lane returns byte (i mod 8) of register base + (i div 8). Byte 0 is the least significant byte of a register.
- R4: An index equal to or greater than the table size in bytes returns byte k of the default word in lane k.
- R5: Index bytes are unsigned, so any index from 0x80 to 0xFF always returns the default byte.
- R6: If base + (i div 8) exceeds 31, the lane returns the default byte even when i is below the table size.
- R7: done_o is high for exactly the one cycle after a cycle with start_i high. result_o changes in that same cycle.
- R8: result_o holds its value in every cycle that does not follow a start.
- R9: With wr_en_i high, wr_data_i is stored in register wr_addr_i at the clock edge. A lookup issued in the same cycle as a write sees the old register contents, and the next lookup sees the new contents.
- R10: Reset drives result_o and done_o to zero and clears every register to zero.
- R11: Starts on consecutive cycles each produce their own result, one cycle after their own start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register file write enable |
| wr_addr_i | input | 5 | Register number to write |
| wr_data_i | input | 64 | Data to write |
| start_i | input | 1 | Issue a lookup with the current operands |
| desc_i | input | 7 | {base register, length code} |
| idx_i | input | 64 | Eight index bytes, one per lane |
| dflt_i | input | 64 | Default bytes for out-of-range lanes |
| result_o | output | 64 | Assembled lookup result |
| done_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
The bench loads every register with bytes that encode their own position, so a wrong register or a wrong byte selection shows up as a distinct value. It checks indexes at the last legal byte and the first illegal byte for each length code. A design with an off-by-one error in the bound would return table data where default data is expected. It also checks indexes with the top bit set, which a design that treats index bytes as signed would accept. It uses bases near register 31, where a design that wraps the register number would read from register 0. Finally, it writes a register in the same cycle as a lookup that reads it, to catch a design that forwards the write data or reads the register one cycle late.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = DATA_W / BYTE_W;
  localparam int unsigned NREG   = 32;
  localparam int unsigned REG_AW = $clog2(NREG);
  localparam int unsigned LEN_W  = 2;
  localparam int unsigned DESC_W = LEN_W + REG_AW;
endpackage

// File: rtl/tbl_regfile.sv
module tbl_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 64,
  parameter int unsigned AW   = 5,
  parameter int unsigned NRD  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [NRD-1:0][AW-1:0]   raddr_i,
  output logic [NRD-1:0][DW-1:0]   rdata_o
);
  logic [DW-1:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NREG); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < int'(NRD); g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end
endmodule

// File: rtl/tbl_lane.sv
module tbl_lane #(
  parameter int unsigned BW    = 8,
  parameter int unsigned DW    = 64,
  parameter int unsigned AW    = 5,
  parameter int unsigned LEN_W = 2,
  parameter int unsigned NREG  = 32
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [AW-1:0]    base_i,
  input  logic [BW-1:0]    idx_i,
  input  logic [BW-1:0]    dflt_i,
  output logic [AW-1:0]    raddr_o,
  input  logic [DW-1:0]    rdata_i,
  output logic [BW-1:0]    byte_o
);
  localparam int unsigned SEL_W = $clog2(DW / BW);
  localparam int unsigned OFS_W = BW - SEL_W;
  localparam int unsigned SUM_W = ((AW > OFS_W) ? AW : OFS_W) + 1;

  logic [BW:0]        tbl_bytes;
  logic [OFS_W-1:0]   reg_ofs;
  logic [SUM_W-1:0]   reg_sum;
  logic [SEL_W-1:0]   sel;
  logic               in_tbl, in_rf, hit;

  // table size in bytes: (len+1) registers of DW/BW bytes
  assign tbl_bytes = ((BW+1)'(len_i) + (BW+1)'(1)) << SEL_W;
  assign reg_ofs   = idx_i[BW-1:SEL_W];
  assign reg_sum   = SUM_W'(base_i) + SUM_W'(reg_ofs);
  assign sel       = idx_i[SEL_W-1:0];
  assign in_tbl    = {1'b0, idx_i} < tbl_bytes;
  // a table running past the last register is out of range, no wrap
  assign in_rf     = reg_sum <= SUM_W'(NREG - 1);
  assign hit       = in_tbl && in_rf;
  assign raddr_o   = reg_sum[AW-1:0];
  assign byte_o    = hit ? rdata_i[BW*sel +: BW] : dflt_i;
endmodule

// File: rtl/byte_tbl_lookup.sv
module byte_tbl_lookup
  import tbl_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned BW    = BYTE_W,
  parameter int unsigned NR    = NREG,
  parameter int unsigned LW    = LEN_W,
  localparam int unsigned NL   = DW / BW,
  localparam int unsigned AW   = $clog2(NR),
  localparam int unsigned DSW  = LW + AW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic           start_i,
  input  logic [DSW-1:0] desc_i,
  input  logic [DW-1:0]  idx_i,
  input  logic [DW-1:0]  dflt_i,
  output logic [DW-1:0]  result_o,
  output logic           done_o
);
  logic [LW-1:0]         len;
  logic [AW-1:0]         base;
  logic [NL-1:0][AW-1:0] raddr;
  logic [NL-1:0][DW-1:0] rdata;
  logic [DW-1:0]         result_d, result_q;
  logic                  done_q;

  assign len  = desc_i[LW-1:0];
  assign base = desc_i[DSW-1:LW];

  tbl_regfile #(.NREG(NR), .DW(DW), .AW(AW), .NRD(NL)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  for (genvar k = 0; k < int'(NL); k++) begin : g_lane
    tbl_lane #(.BW(BW), .DW(DW), .AW(AW), .LEN_W(LW), .NREG(NR)) u_lane (
      .len_i   (len),
      .base_i  (base),
      .idx_i   (idx_i[k*BW +: BW]),
      .dflt_i  (dflt_i[k*BW +: BW]),
      .raddr_o (raddr[k]),
      .rdata_i (rdata[k]),
      .byte_o  (result_d[k*BW +: BW])
    );
  end

  // lookup is evaluated at the start edge; a same-edge write is not visible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= start_i;
      if (start_i) result_q <= result_d;
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;
endmodule

// File: rtl/byte_tbl_lookup_chk.sv
module byte_tbl_lookup_chk
  import tbl_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic [DESC_W-1:0]   desc_i,
  input logic [DATA_W-1:0]   idx_i,
  input logic [DATA_W-1:0]   dflt_i,
  input logic [DATA_W-1:0]   result_o,
  input logic                done_o
);
  logic [BYTE_W:0] lim0;
  logic [BYTE_W:0] last0;
  assign lim0  = ((BYTE_W+1)'(desc_i[LEN_W-1:0]) + (BYTE_W+1)'(1)) * (BYTE_W+1)'(LANES);
  assign last0 = (BYTE_W+1)'(desc_i[DESC_W-1:LEN_W]) + (BYTE_W+1)'(idx_i[BYTE_W-1:3]);

  a_r7_done_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  a_r7_no_stray_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);

  a_r8_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(result_o));

  a_r4_beyond_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ({1'b0, idx_i[BYTE_W-1:0]} >= lim0))
      |=> result_o[BYTE_W-1:0] == $past(dflt_i[BYTE_W-1:0]));

  a_r5_top_bit_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && idx_i[BYTE_W-1])
      |=> result_o[BYTE_W-1:0] == $past(dflt_i[BYTE_W-1:0]));

  a_r6_past_last_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (last0 > (BYTE_W+1)'(NREG - 1)))
      |=> result_o[BYTE_W-1:0] == $past(dflt_i[BYTE_W-1:0]));
endmodule

bind byte_tbl_lookup byte_tbl_lookup_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .desc_i   (desc_i),
  .idx_i    (idx_i),
  .dflt_i   (dflt_i),
  .result_o (result_o),
  .done_o   (done_o)
);

// File: tb/byte_tbl_lookup_tb.sv
`timescale 1ns/1ps
module byte_tbl_lookup_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        start_i = 1'b0;
  logic [6:0]  desc_i = '0;
  logic [63:0] idx_i = '0;
  logic [63:0] dflt_i = '0;
  logic [63:0] result_o;
  logic        done_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [63:0] exp_mem [32];

  always #2.5 clk_i = ~clk_i;

  byte_tbl_lookup u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .start_i(start_i), .desc_i(desc_i), .idx_i(idx_i),
    .dflt_i(dflt_i), .result_o(result_o), .done_o(done_o)
  );

  typedef struct packed {
    logic [6:0]  desc;
    logic [63:0] idx;
    logic [63:0] dflt;
  } vec_t;

  // desc = {base[4:0], len[1:0]}
  localparam vec_t VECS [8] = '{
    '{{5'd0,  2'd0}, 64'h0706050403020100, 64'hAAAAAAAAAAAAAAAA},
    '{{5'd0,  2'd3}, 64'h2000011F07081009, 64'h5555555555555555},
    '{{5'd3,  2'd1}, 64'h0F10000E11031F02, 64'hC3C3C3C3C3C3C3C3},
    '{{5'd4,  2'd3}, 64'h80FF7F1F00817E01, 64'h0123456789ABCDEF},
    '{{5'd30, 2'd3}, 64'h100F0807001F0918, 64'hFEDCBA9876543210},
    '{{5'd31, 2'd0}, 64'h0708000109060F05, 64'h1122334455667788},
    '{{5'd2,  2'd2}, 64'h1718161900050F10, 64'h99999999999999AA},
    '{{5'd8,  2'd1}, 64'h0001020304050607, 64'h0000000000000000}
  };

  function automatic logic [63:0] model(input logic [6:0] d, input logic [63:0] ix,
                                        input logic [63:0] df);
    logic [63:0] r;
    int len, base, i, reg_n;
    len  = int'(d[1:0]);
    base = int'(d[6:2]);
    for (int k = 0; k < 8; k++) begin
      i = int'(ix[8*k +: 8]);
      reg_n = base + i / 8;
      if (i < (len + 1) * 8 && reg_n <= 31) r[8*k +: 8] = exp_mem[reg_n][8*(i%8) +: 8];
      else r[8*k +: 8] = df[8*k +: 8];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [63:0] v);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = v;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    exp_mem[a] = v;
  endtask

  task automatic lookup(input string req, input logic [6:0] d, input logic [63:0] ix,
                        input logic [63:0] df);
    logic [63:0] e;
    e = model(d, ix, df);
    @(negedge clk_i);
    start_i = 1'b1; desc_i = d; idx_i = ix; dflt_i = df;
    @(negedge clk_i);
    start_i = 1'b0;
    check({req, " result"}, result_o, e);
    check({req, " R7 done"}, 64'(done_o), 64'd1);
  endtask

  initial begin
    for (int r = 0; r < 32; r++) exp_mem[r] = '0;
    repeat (3) @(negedge clk_i);
    // R10: reset state
    check("R10 reset result", result_o, 64'd0);
    check("R10 reset done", 64'(done_o), 64'd0);
    rst_ni = 1'b1;
    // R10: registers clear after reset
    lookup("R10 cleared regs", {5'd0, 2'd3}, 64'h1F18100800010203, 64'hFFFFFFFFFFFFFFFF);

    // preload: byte j of register r holds r*8+j
    for (int r = 0; r < 32; r++) begin
      logic [63:0] v;
      for (int j = 0; j < 8; j++) v[8*j +: 8] = 8'(r * 8 + j);
      wr(5'(r), v);
    end

    // R1 R2 R3 R4 R5 R6: vector table
    for (int n = 0; n < 8; n++)
      lookup($sformatf("R1/R3 R2 R4 R5 R6 vec%0d", n), VECS[n].desc, VECS[n].idx, VECS[n].dflt);

    // R3: explicit value, base 3 index 0x0F -> reg 4 byte 7 = 0x27
    lookup("R3 direct", {5'd3, 2'd1}, 64'h000000000000000F, 64'hEEEEEEEEEEEEEEEE);
    check("R3 value", {56'd0, result_o[7:0]}, 64'h27);
    // R4: first illegal index per length code
    for (int l = 0; l < 4; l++) begin
      logic [7:0] bnd;
      bnd = 8'((l + 1) * 8);
      lookup("R4 bound", {5'd0, 2'(l)}, {56'd0, bnd}, 64'h00000000000000D1);
      check("R4 default byte", {56'd0, result_o[7:0]}, 64'hD1);
      lookup("R4 last legal", {5'd0, 2'(l)}, {56'd0, bnd - 8'd1}, 64'h00000000000000D1);
      check("R4 last legal byte", {56'd0, result_o[7:0]}, {56'd0, bnd - 8'd1});
    end
    // R6: base 31, len 1, index 8 -> would be reg 32 -> default
    lookup("R6 no wrap", {5'd31, 2'd1}, 64'h0000000000000008, 64'h00000000000000B7);
    check("R6 default byte", {56'd0, result_o[7:0]}, 64'hB7);

    // R8: hold and no done when idle
    @(negedge clk_i);
    check("R8 hold", result_o, model({5'd31, 2'd1}, 64'h8, 64'hB7));
    check("R7 done low", 64'(done_o), 64'd0);
    @(negedge clk_i);
    idx_i = 64'h0001020304050607;
    @(negedge clk_i);
    check("R8 idle operand change", result_o, model({5'd31, 2'd1}, 64'h8, 64'hB7));

    // R9: write in the same cycle as a lookup sees old data
    begin
      logic [63:0] old_e, new_e;
      old_e = model({5'd5, 2'd0}, 64'h0706050403020100, 64'h0);
      @(negedge clk_i);
      wr_en_i = 1'b1; wr_addr_i = 5'd5; wr_data_i = 64'hDEADBEEFCAFEF00D;
      start_i = 1'b1; desc_i = {5'd5, 2'd0}; idx_i = 64'h0706050403020100; dflt_i = '0;
      @(negedge clk_i);
      wr_en_i = 1'b0; start_i = 1'b0;
      exp_mem[5] = 64'hDEADBEEFCAFEF00D;
      check("R9 same-cycle old data", result_o, old_e);
      new_e = model({5'd5, 2'd0}, 64'h0706050403020100, 64'h0);
      lookup("R9 new data", {5'd5, 2'd0}, 64'h0706050403020100, 64'h0);
      check("R9 new value", result_o, 64'hDEADBEEFCAFEF00D);
      check("R9 model agree", new_e, 64'hDEADBEEFCAFEF00D);
    end

    // R11: back-to-back starts
    begin
      logic [63:0] e1, e2;
      e1 = model({5'd1, 2'd0}, 64'h0001020304050607, 64'h0);
      e2 = model({5'd9, 2'd3}, 64'h1F20001008FF0102, 64'h6666666666666666);
      @(negedge clk_i);
      start_i = 1'b1; desc_i = {5'd1, 2'd0}; idx_i = 64'h0001020304050607; dflt_i = '0;
      @(negedge clk_i);
      check("R11 first", result_o, e1);
      check("R11 first done", 64'(done_o), 64'd1);
      desc_i = {5'd9, 2'd3}; idx_i = 64'h1F20001008FF0102; dflt_i = 64'h6666666666666666;
      @(negedge clk_i);
      start_i = 1'b0;
      check("R11 second", result_o, e2);
      check("R11 second done", 64'(done_o), 64'd1);
      @(negedge clk_i);
      check("R11 done falls", 64'(done_o), 64'd0);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule